// File: doc/BRIEF.md
# SPI configuration and chip-select controller

This block holds the control word of a four-line SPI master and turns it into the settings and select lines that the serial engine and the board use. A small register port (one address line, one write strobe, a combinational read) reaches two registers: the control word and a one-bit enable register. The block drives the clock polarity, clock phase and divisor code that the engine runs with, a one-cycle manual start pulse, and four registered chip-select lines.

The clock settings that the engine sees are a shadow copy of the control word. They are reloaded only when software turns the enable register from off to on. This means a polarity or phase change made while the controller runs cannot create a spurious edge on the serial clock. The chip-select field is either a one-hot active-low pattern, one line per device, or a raw 4-bit device code for an external decoder. Software may force the lines from the field, or let them follow the engine's busy signal.

Top module: `spi_cfg_ctrl`

## Requirements
- R1: After reset the control word reads 0x00007C09, which has master enable set, divisor code 1, all four select bits high and force set. The enable register reads 0, `cs_n` is 4'hF, the live polarity, phase and divisor are 0, 0 and 1, and `start_pulse` is low.
- R2: A write with `reg_addr`=0 stores the control fields. Master enable is bit 0, polarity bit 1, phase bit 2, divisor bits 5:3, decode bit 9, select field bits 13:10, force bit 14 and manual-start enable bit 15. Reading address 0 returns them, with bits 8:6, bit 16 and all higher bits reading 0.
- R3: A write with `reg_addr`=1 sets the enable register from bit 0, and reading address 1 returns it in bit 0 with all other bits 0. While it is 0, `cs_n` is 4'hF one cycle later, whatever the field, force or busy values.
- R4: `sclk_cpol`, `sclk_cpha` and `sclk_div` do not change on control writes. They take the stored polarity, phase and divisor on the clock edge of an enable write of 1 made while the enable register is 0. An enable write of 1 while it is already 1 reloads nothing.
- R5: While enabled and with force (bit 14) set, `cs_n` equals the select field one cycle after the registers hold it.
- R6: While enabled and with force clear, `cs_n` equals the field in the cycle after `engine_busy` is sampled high, and 4'hF in the cycle after it is sampled low.
- R7: In direct mode (bit 9 = 0), selecting device n is done by the field pattern with only bit n low, and that pattern reaches `cs_n` unchanged. In decode mode (bit 9 = 1) the field is a binary device code passed unchanged to `cs_n`, and `cs_decoded` follows bit 9.
- R8: A control write with bits 15 and 16 both set makes `start_pulse` high for exactly the following cycle. A write with bit 16 set and bit 15 clear makes no pulse.
- R9: `ctrl_active` is high exactly when the enable register and master enable (bit 0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control word, 1 enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| engine_busy | input | 1 | Serial engine is shifting a frame |
| ctrl_active | output | 1 | Controller enabled and in master mode |
| sclk_cpol | output | 1 | Live clock polarity |
| sclk_cpha | output | 1 | Live clock phase |
| sclk_div | output | 3 | Live divisor code |
| cs_decoded | output | 1 | Select lines carry a binary device code |
| start_pulse | output | 1 | One-cycle manual start request |
| cs_n | output | 4 | Chip-select lines, active low in direct mode |

## Verification
The bench builds the block with its default 32-bit data width. At that width the read-back of the unused bits 8:6, the start bit and the whole upper half can be checked against zero, and a write of all ones reaches every field at once. The reference model tracks the stored word, the enable bit and the shadowed clock settings. This exposes a reload on a repeated enable write, and select lines that follow busy while forced or ignore the disabled state.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  // control word layout (bit positions are decoded by the engine and software)
  localparam int unsigned POS_MEN    = 0;
  localparam int unsigned POS_CPOL   = 1;
  localparam int unsigned POS_CPHA   = 2;
  localparam int unsigned DIV_LSB    = 3;
  localparam int unsigned DIV_W      = 3;
  localparam int unsigned POS_DEC    = 9;
  localparam int unsigned SEL_LSB    = 10;
  localparam int unsigned SEL_W      = 4;
  localparam int unsigned POS_FORCE  = 14;
  localparam int unsigned POS_MSE    = 15;
  localparam int unsigned POS_MSTART = 16;
  localparam int unsigned STORE_W    = 16;

  localparam logic [STORE_W-1:0] STORE_MASK =
      STORE_W'((1 << (DIV_LSB + DIV_W)) - 1) |
      STORE_W'(((1 << (POS_MSE + 1)) - 1) & ~((1 << POS_DEC) - 1));

  localparam logic [STORE_W-1:0] CTRL_RESET =
      STORE_W'(1 << POS_MEN) |
      STORE_W'(1 << DIV_LSB) |
      STORE_W'(((1 << SEL_W) - 1) << SEL_LSB) |
      STORE_W'(1 << POS_FORCE);

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic [DIV_W-1:0] div;
  } clk_cfg_t;

  localparam clk_cfg_t CLK_RESET = '{cpol: 1'b0, cpha: 1'b0, div: DIV_W'(1)};
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [STORE_W-1:0]  ctrl_q,
  output logic                en_q,
  output logic                en_rise,
  output logic                start_q
);
  logic ctrl_wr, en_wr, start_req;

  assign ctrl_wr   = wr && !addr;
  assign en_wr     = wr && addr;
  assign en_rise   = en_wr && wdata[0] && !en_q;
  assign start_req = ctrl_wr && wdata[POS_MSE] && wdata[POS_MSTART];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      en_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_req;
      if (ctrl_wr) ctrl_q <= wdata[STORE_W-1:0] & STORE_MASK;
      if (en_wr)   en_q   <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) rdata[STORE_W-1:0] = ctrl_q;
    else       rdata[0]           = en_q;
  end
endmodule

// File: rtl/spi_cfg_clkhold.sv
module spi_cfg_clkhold
  import spi_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [STORE_W-1:0] ctrl_q,
  output clk_cfg_t           live
);
  clk_cfg_t staged;

  always_comb begin
    staged.cpol = ctrl_q[POS_CPOL];
    staged.cpha = ctrl_q[POS_CPHA];
    staged.div  = ctrl_q[DIV_LSB +: DIV_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    live <= CLK_RESET;
    else if (load) live <= staged;
  end
endmodule

// File: rtl/spi_cfg_csgen.sv
module spi_cfg_csgen #(
  parameter int unsigned LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enabled,
  input  logic             force_sel,
  input  logic             busy,
  input  logic [LINES-1:0] field,
  output logic [LINES-1:0] cs_q
);
  logic drive;

  assign drive = enabled && (force_sel || busy);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_q[i] <= 1'b1;
      else        cs_q[i] <= drive ? field[i] : 1'b1;
    end
  end
endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              engine_busy,
  output logic              ctrl_active,
  output logic              sclk_cpol,
  output logic              sclk_cpha,
  output logic [DIV_W-1:0]  sclk_div,
  output logic              cs_decoded,
  output logic              start_pulse,
  output logic [SEL_W-1:0]  cs_n
);
  logic [STORE_W-1:0] ctrl_q;
  logic               en_q;
  logic               en_rise;
  clk_cfg_t           live;

  spi_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .ctrl_q  (ctrl_q),
    .en_q    (en_q),
    .en_rise (en_rise),
    .start_q (start_pulse)
  );

  spi_cfg_clkhold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (en_rise),
    .ctrl_q (ctrl_q),
    .live   (live)
  );

  spi_cfg_csgen #(.LINES(SEL_W)) u_cs (
    .clk       (clk),
    .rst_n     (rst_n),
    .enabled   (en_q),
    .force_sel (ctrl_q[POS_FORCE]),
    .busy      (engine_busy),
    .field     (ctrl_q[SEL_LSB +: SEL_W]),
    .cs_q      (cs_n)
  );

  assign sclk_cpol   = live.cpol;
  assign sclk_cpha   = live.cpha;
  assign sclk_div    = live.div;
  assign cs_decoded  = ctrl_q[POS_DEC];
  assign ctrl_active = en_q && ctrl_q[POS_MEN];
endmodule

// File: rtl/spi_cfg_ctrl_chk.sv
module spi_cfg_ctrl_chk
  import spi_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               engine_busy,
  input logic               sclk_cpol,
  input logic               sclk_cpha,
  input logic [DIV_W-1:0]   sclk_div,
  input logic               start_pulse,
  input logic [SEL_W-1:0]   cs_n,
  input logic [STORE_W-1:0] ctrl_q,
  input logic               en_q
);
  a_r8_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(reg_wr && !reg_addr && reg_wdata[POS_MSE] && reg_wdata[POS_MSTART]));

  a_r4_live_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && reg_addr && reg_wdata[0] && !en_q)
      |-> ($stable(sclk_cpol) && $stable(sclk_cpha) && $stable(sclk_div)));

  a_r3_off_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_q) |-> (cs_n == '1));

  a_r6_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q && !ctrl_q[POS_FORCE] && !engine_busy) |-> (cs_n == '1));

  a_r5_forced_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q && ctrl_q[POS_FORCE]) |-> (cs_n == $past(ctrl_q[SEL_LSB +: SEL_W])));

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> ((reg_rdata[DATA_W-1:STORE_W] == '0) && (reg_rdata[8:6] == '0)));
endmodule

bind spi_cfg_ctrl spi_cfg_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .engine_busy (engine_busy),
  .sclk_cpol   (sclk_cpol),
  .sclk_cpha   (sclk_cpha),
  .sclk_div    (sclk_div),
  .start_pulse (start_pulse),
  .cs_n        (cs_n),
  .ctrl_q      (ctrl_q),
  .en_q        (en_q)
);

// File: tb/test_spi_cfg_ctrl.sv
module test_spi_cfg_ctrl;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_addr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              engine_busy = 1'b0;
  logic              ctrl_active, sclk_cpol, sclk_cpha, cs_decoded, start_pulse;
  logic [2:0]        sclk_div;
  logic [3:0]        cs_n;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_cfg_ctrl #(.DATA_W(DATA_W)) i_spi_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .engine_busy(engine_busy),
    .ctrl_active(ctrl_active), .sclk_cpol(sclk_cpol), .sclk_cpha(sclk_cpha),
    .sclk_div(sclk_div), .cs_decoded(cs_decoded), .start_pulse(start_pulse),
    .cs_n(cs_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  int m_ctrl = 'h7C09, m_en = 0, m_cpol = 0, m_cpha = 0, m_div = 1, m_start = 0, m_cs = 15;

  always @(posedge clk) begin
    if (rst_n) begin
      int cs_next;
      if (m_en == 0) cs_next = 15;
      else if (((m_ctrl >> 14) & 1) == 1 || engine_busy) cs_next = (m_ctrl >> 10) & 15;
      else cs_next = 15;
      m_start = (reg_wr && !reg_addr && reg_wdata[15] && reg_wdata[16]) ? 1 : 0;
      if (reg_wr && reg_addr) begin
        if (reg_wdata[0] && m_en == 0) begin
          m_cpol = (m_ctrl >> 1) & 1;
          m_cpha = (m_ctrl >> 2) & 1;
          m_div  = (m_ctrl >> 3) & 7;
        end
        m_en = reg_wdata[0] ? 1 : 0;
      end
      if (reg_wr && !reg_addr) m_ctrl = int'(reg_wdata) & 'hFE3F;
      m_cs = cs_next;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 rdata", reg_rdata, reg_addr ? 32'(m_en) : 32'(m_ctrl));
      check("R4 cpol", 32'(sclk_cpol), 32'(m_cpol));
      check("R4 cpha", 32'(sclk_cpha), 32'(m_cpha));
      check("R4 div", 32'(sclk_div), 32'(m_div));
      check("R8 start", 32'(start_pulse), 32'(m_start));
      check("R6 cs_n", 32'(cs_n), 32'(m_cs));
      check("R7 decoded", 32'(cs_decoded), 32'((m_ctrl >> 9) & 1));
      check("R9 active", 32'(ctrl_active), 32'(m_en & m_ctrl & 1));
    end
  end

  task automatic write_reg(input logic a, input logic [31:0] d);
    @(posedge clk); #(CLK_P/4);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #(CLK_P/4);
    reg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check("R1 cs_n", 32'(cs_n), 32'hF);
    check("R1 ctrl", reg_rdata, 32'h7C09);
    check("R1 live", {29'd0, sclk_cpol, sclk_cpha, 1'b0} | 32'(sclk_div), 32'd1);
    check("R1 start", 32'(start_pulse), 32'd0);
    rst_n = 1'b1;

    // R3 enable on, R5 forced default field
    write_reg(1'b1, 32'h1);
    settle();
    check("R3 en read", reg_rdata, 32'h1);
    check("R5 forced all high", 32'(cs_n), 32'hF);

    // R4: control write alone leaves live settings
    write_reg(1'b0, 32'h0000_782F); // force, field 1110, div 5, cpha, cpol, men
    settle();
    check("R4 cpol held", 32'(sclk_cpol), 32'd0);
    check("R5 forced dev0", 32'(cs_n), 32'hE);
    write_reg(1'b1, 32'h1);
    settle();
    check("R4 no reload when on", 32'(sclk_div), 32'd1);
    write_reg(1'b1, 32'h0);
    write_reg(1'b1, 32'h1);
    settle();
    check("R4 reload cpol", 32'(sclk_cpol), 32'd1);
    check("R4 reload div", 32'(sclk_div), 32'd5);

    // R7 direct mode: one low bit per device
    for (int n = 0; n < 4; n++) begin
      write_reg(1'b0, 32'h4001 | (32'((~(4'b1 << n)) & 4'hF) << 10));
      settle();
      check("R7 direct dev", 32'(cs_n), 32'((~(4'b1 << n)) & 4'hF));
    end

    // R6 busy-driven selects
    write_reg(1'b0, 32'h0000_3401); // field 1101, no force
    settle();
    check("R6 idle", 32'(cs_n), 32'hF);
    @(posedge clk); #(CLK_P/4); engine_busy = 1'b1;
    settle();
    check("R6 busy", 32'(cs_n), 32'hD);
    @(posedge clk); #(CLK_P/4); engine_busy = 1'b0;
    settle();
    check("R6 released", 32'(cs_n), 32'hF);

    // R7 decode mode
    write_reg(1'b0, 32'h0000_4A01); // force, field 0010, decode
    settle();
    check("R7 code", 32'(cs_n), 32'h2);
    check("R7 flag", 32'(cs_decoded), 32'd1);

    // R8 manual start
    write_reg(1'b0, 32'h0001_C001);
    @(negedge clk);
    check("R8 pulse high", 32'(start_pulse), 32'd1);
    @(negedge clk);
    check("R8 pulse low", 32'(start_pulse), 32'd0);
    write_reg(1'b0, 32'h0001_4001);
    @(negedge clk);
    check("R8 no enable no pulse", 32'(start_pulse), 32'd0);
    check("R2 start bit reads 0", reg_rdata, 32'h0000_4001);

    // R2 all ones
    write_reg(1'b0, 32'hFFFF_FFFF);
    settle();
    check("R2 mask", reg_rdata, 32'h0000_FE3F);
    check("R9 active", 32'(ctrl_active), 32'd1);

    // R3 disable deselects, R9 inactive
    write_reg(1'b1, 32'hFFFF_FFFE);
    @(posedge clk); #(CLK_P/4); engine_busy = 1'b1; reg_addr = 1'b1;
    settle();
    check("R3 off cs_n", 32'(cs_n), 32'hF);
    check("R3 en read", reg_rdata, 32'h0);
    check("R9 inactive", 32'(ctrl_active), 32'd0);
    engine_busy = 1'b0;
    settle();
    summary();
  end
endmodule